// File: doc/BRIEF.md
# Timestamped Event Cluster Packer

This block sits on the capture side of a 16-channel logic analyzer. Once per base tick of 20 ns it takes one 16-bit bus of raw samples and rearranges it into an event word. The mode input sets how the 16 bits are divided: one sample for each of 16 channels, two samples for each of 8 channels, or four samples for each of 4 channels. In the event word, the samples of one channel sit together.

Seven recorded events, together with the 16-bit tick count at the first of them, form a 16-byte cluster. Each cluster leaves the block as a burst of bytes, one byte per clock, tagged with its byte offset inside a 1024-byte chunk. A strobe marks the last byte of each chunk. A tick whose record flag is low still advances the timestamp but stores nothing. A jump between consecutive cluster timestamps that is larger than seven therefore encodes a span in which the input held its last value.

Top module: `evpk_packer`

## Requirements
- R1: While reset is held and in the first cycle after it is released, out_valid and chunk_done are 0 and out_data is 0.
- R2: With mode 0, the event word equals the sample bus unchanged: bit l is channel l.
- R3: With mode 1 (8 channels, 2 samples), input bit k*8+l (sample k of channel l) lands at event bit l*2+k.
- R4: With mode 2 (4 channels, 4 samples), input bit k*4+l lands at event bit l*4+k.
- R5: Mode 3 packs exactly like mode 0.
- R6: A cluster is 16 bytes, little-endian: bytes 0 and 1 hold the timestamp (low byte first), and bytes 2+2j and 3+2j hold the low and high byte of event j, for j from 0 to 6 in arrival order.
- R7: No byte is emitted until seven events have been recorded. Six recorded events produce no output, and the seventh releases the cluster.
- R8: The timestamp counts every tick from 0 after reset, modulo 2^16. A cluster's timestamp is the count at its first event, so the count wraps from 0xFFFF to 0x0000.
- R9: A tick with keep low records nothing, but it still advances the timestamp by one.
- R10: out_addr equals cluster_index*16 + byte_index within the chunk. chunk_done is high only together with the byte at address 1023. After the 64th cluster, addresses restart at 0.
- R11: If the seventh event is sampled at rising edge E, byte 0 is valid from edge E+1. The 16 bytes then follow on consecutive cycles, with addresses rising by one each cycle. Recorded ticks must be at least 3 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One pulse per 20 ns base tick |
| keep | input | 1 | Record this tick as an event |
| mode | input | 2 | 0: 16x1, 1: 8x2, 2: 4x4, 3: as 0 |
| samples | input | 16 | Raw samples, sample-major (bit k*C+l) |
| out_valid | output | 1 | out_data holds a cluster byte |
| out_data | output | 8 | Cluster byte |
| out_addr | output | 10 | Byte offset inside the chunk |
| chunk_done | output | 1 | Last byte of a chunk |

## Verification
The bench drives each mode with patterns chosen so that a swapped sample and channel index would move bits visibly. A wrong index formula scrambles the event bytes, and mode 3 falling into the wrong arm would show up as an interleaved word. It sends clusters separated by unrecorded ticks, and it runs the tick count through 0xFFFF. A design that stamps the last event instead of the first, stalls the timestamp on ticks that are not recorded, or saturates the count would produce a wrong header. A run of 65 clusters checks the chunk strobe and the address wrap: an off-by-one strobe or an address that does not wrap would fail there. A cycle-exact test checks the two-edge start of the burst.

// File: rtl/evpk_pkg.sv
`timescale 1ns/1ps
package evpk_pkg;
    localparam int WORD_W       = 16;
    localparam int EV_PER_CL    = 7;
    localparam int CL_PER_CHUNK = 64;

    typedef enum logic [1:0] {
        MODE_16X1 = 2'd0,
        MODE_8X2  = 2'd1,
        MODE_4X4  = 2'd2,
        MODE_ALT  = 2'd3
    } evpk_mode_e;
endpackage

// File: rtl/evpk_lane_mux.sv
`timescale 1ns/1ps
module evpk_lane_mux
    import evpk_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [1:0]   mode,
    input  logic [W-1:0] raw,
    output logic [W-1:0] word
);
    localparam int C2 = W / 2;
    localparam int C4 = W / 4;

    logic [W-1:0] w2, w4;

    for (genvar l = 0; l < C2; l++) begin : g_two
        for (genvar k = 0; k < 2; k++) begin : g_smp
            assign w2[l*2 + k] = raw[k*C2 + l];
        end
    end

    for (genvar l = 0; l < C4; l++) begin : g_four
        for (genvar k = 0; k < 4; k++) begin : g_smp
            assign w4[l*4 + k] = raw[k*C4 + l];
        end
    end

    always_comb begin
        case (evpk_mode_e'(mode))
            MODE_8X2: word = w2;
            MODE_4X4: word = w4;
            default:  word = raw;
        endcase
    end
endmodule

// File: rtl/evpk_cluster_asm.sv
`timescale 1ns/1ps
module evpk_cluster_asm
    import evpk_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int EV = EV_PER_CL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          keep,
    input  logic [W-1:0]  word,
    output logic          ready,
    output logic [W-1:0]  hdr,
    output logic [EV*W-1:0] evs
);
    localparam int CNT_W = $clog2(EV);

    typedef struct packed {
        logic [CNT_W-1:0] ev_cnt;
        logic [W-1:0]     ts;
        logic [W-1:0]     hdr;
        logic [EV*W-1:0]  evs;
        logic             ready;
    } asm_st_t;

    asm_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b0;
        if (tick) begin
            st_d.ts = st_q.ts + W'(1);
            if (keep) begin
                if (st_q.ev_cnt == '0) st_d.hdr = st_q.ts;
                st_d.evs[st_q.ev_cnt*W +: W] = word;
                if (st_q.ev_cnt == CNT_W'(EV-1)) begin
                    st_d.ev_cnt = '0;
                    st_d.ready  = 1'b1;
                end else begin
                    st_d.ev_cnt = st_q.ev_cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready = st_q.ready;
    assign hdr   = st_q.hdr;
    assign evs   = st_q.evs;
endmodule

// File: rtl/evpk_serializer.sv
`timescale 1ns/1ps
module evpk_serializer
    import evpk_pkg::*;
#(
    parameter int BYTES    = 2 + 2*EV_PER_CL,
    parameter int CLUSTERS = CL_PER_CHUNK,
    parameter int ADDR_W   = $clog2(BYTES*CLUSTERS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [BYTES*8-1:0] frame,
    output logic               out_valid,
    output logic [7:0]         out_data,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               chunk_done
);
    localparam int BI_W = $clog2(BYTES);
    localparam int CI_W = $clog2(CLUSTERS);

    typedef struct packed {
        logic               busy;
        logic [BYTES*8-1:0] shift;
        logic [BI_W-1:0]    byte_idx;
        logic [CI_W-1:0]    cl_idx;
    } ser_st_t;

    ser_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.busy     = 1'b1;
            st_d.shift    = frame;
            st_d.byte_idx = '0;
        end else if (st_q.busy) begin
            st_d.shift = st_q.shift >> 8;
            if (st_q.byte_idx == BI_W'(BYTES-1)) begin
                st_d.busy     = 1'b0;
                st_d.byte_idx = '0;
                st_d.cl_idx   = (st_q.cl_idx == CI_W'(CLUSTERS-1)) ? '0
                                : st_q.cl_idx + CI_W'(1);
            end else begin
                st_d.byte_idx = st_q.byte_idx + BI_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.busy;
    assign out_data   = st_q.shift[7:0];
    assign out_addr   = ADDR_W'(int'(st_q.cl_idx) * BYTES + int'(st_q.byte_idx));
    assign chunk_done = st_q.busy && (st_q.byte_idx == BI_W'(BYTES-1))
                        && (st_q.cl_idx == CI_W'(CLUSTERS-1));
endmodule

// File: rtl/evpk_packer.sv
`timescale 1ns/1ps
module evpk_packer
    import evpk_pkg::*;
#(
    parameter int EV       = EV_PER_CL,
    parameter int CLUSTERS = CL_PER_CHUNK
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        keep,
    input  logic [1:0]  mode,
    input  logic [15:0] samples,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic [$clog2((2+2*EV)*CLUSTERS)-1:0] out_addr,
    output logic        chunk_done
);
    localparam int W      = WORD_W;
    localparam int BYTES  = 2 + 2*EV;
    localparam int ADDR_W = $clog2(BYTES*CLUSTERS);

    logic [W-1:0]    word;
    logic            ready;
    logic [W-1:0]    hdr;
    logic [EV*W-1:0] evs;

    evpk_lane_mux #(.W(W)) u_mux (
        .mode (mode),
        .raw  (samples),
        .word (word)
    );

    evpk_cluster_asm #(.W(W), .EV(EV)) u_asm (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .keep  (keep),
        .word  (word),
        .ready (ready),
        .hdr   (hdr),
        .evs   (evs)
    );

    evpk_serializer #(.BYTES(BYTES), .CLUSTERS(CLUSTERS), .ADDR_W(ADDR_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ready),
        .frame      ({evs, hdr}),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_addr   (out_addr),
        .chunk_done (chunk_done)
    );
endmodule

// File: rtl/evpk_packer_chk.sv
`timescale 1ns/1ps
module evpk_packer_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic [7:0]        out_data,
    input logic [ADDR_W-1:0] out_addr,
    input logic              chunk_done
);
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && !chunk_done && out_data == 8'd0));

    a_r10_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_done |-> (out_valid && out_addr == {ADDR_W{1'b1}}));

    a_r11_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_addr[3:0] != 4'hF) |=>
        (out_valid && out_addr == $past(out_addr) + ADDR_W'(1)));

    a_r11_burst_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_addr[3:0] == 4'h0));

    a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_addr == {ADDR_W{1'b1}}) |=> (out_addr[3:0] == 4'h0));
endmodule

bind evpk_packer evpk_packer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_addr   (out_addr),
    .chunk_done (chunk_done)
);

// File: tb/evpk_packer_test.sv
`timescale 1ns/1ps
module evpk_packer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        keep = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [15:0] samples = 16'd0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic [9:0]  out_addr;
    logic        chunk_done;

    always #2.5 clk = ~clk;

    evpk_packer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .keep(keep), .mode(mode),
        .samples(samples), .out_valid(out_valid), .out_data(out_data),
        .out_addr(out_addr), .chunk_done(chunk_done)
    );

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    logic [7:0] cap_d [1200];
    logic [9:0] cap_a [1200];
    logic       cap_c [1200];
    int         cap_n = 0;
    logic       cap_clr = 1'b0;

    logic [7:0]  exp_b [1200];
    int          exp_n = 0;
    logic [15:0] m_ev [7];
    logic [15:0] m_hdr;
    int          m_cnt = 0;
    int          m_ts = 0;

    always @(negedge clk) begin
        if (cap_clr) cap_n = 0;
        else if (rst_n && out_valid && cap_n < 1200) begin
            cap_d[cap_n] = out_data;
            cap_a[cap_n] = out_addr;
            cap_c[cap_n] = chunk_done;
            cap_n++;
        end
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run hung, got %0d cycles expected < 190000", cycles);
            report();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] pack_word(input logic [1:0] md, input logic [15:0] raw);
        int s;
        int c;
        logic [15:0] w;
        s = (md == 2'd1) ? 2 : (md == 2'd2) ? 4 : 1;
        c = 16 / s;
        w = '0;
        for (int k = 0; k < s; k++)
            for (int l = 0; l < c; l++)
                w[l*s + k] = raw[k*c + l];
        return w;
    endfunction

    task automatic model_tick(input bit kp, input logic [1:0] md, input logic [15:0] raw);
        if (kp) begin
            if (m_cnt == 0) m_hdr = m_ts[15:0];
            m_ev[m_cnt] = pack_word(md, raw);
            m_cnt++;
            if (m_cnt == 7) begin
                exp_b[exp_n++] = m_hdr[7:0];
                exp_b[exp_n++] = m_hdr[15:8];
                for (int j = 0; j < 7; j++) begin
                    exp_b[exp_n++] = m_ev[j][7:0];
                    exp_b[exp_n++] = m_ev[j][15:8];
                end
                m_cnt = 0;
            end
        end
        m_ts++;
    endtask

    task automatic push_tick(input bit kp, input logic [1:0] md, input logic [15:0] raw);
        model_tick(kp, md, raw);
        @(posedge clk); #1;
        tick = 1'b1; keep = kp; mode = md; samples = raw;
        @(posedge clk); #1;
        tick = 1'b0; keep = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; tick = 1'b0; keep = 1'b0; mode = 2'd0; samples = '0;
        cap_clr = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1; cap_clr = 1'b0;
        exp_n = 0; m_cnt = 0; m_ts = 0;
    endtask

    task automatic compare(input string req);
        repeat (24) @(posedge clk);
        check(cap_n == exp_n, {req, " byte count"}, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            check(cap_d[i] === exp_b[i], req, cap_d[i], exp_b[i]);
            check(cap_a[i] === 10'(i % 1024), {req, " addr"}, cap_a[i], i % 1024);
        end
    endtask

    task automatic t_reset();
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(!out_valid && !chunk_done && out_data == 8'd0, "R1 in reset",
              {out_valid, chunk_done, out_data}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !chunk_done && out_data == 8'd0, "R1 after release",
              {out_valid, chunk_done, out_data}, 0);
    endtask

    task automatic t_mode(input logic [1:0] md, input string req);
        do_reset();
        for (int i = 0; i < 7; i++)
            push_tick(1'b1, md, (16'h1 << (i*2 + 1)) ^ (16'hA5C3 * 16'(i + 1)));
        compare(req);
    endtask

    task automatic t_layout();
        logic [7:0] lit [16];
        do_reset();
        for (int i = 0; i < 3; i++) push_tick(1'b0, 2'd0, 16'hFFFF);
        for (int j = 0; j < 7; j++) push_tick(1'b1, 2'd0, {8'(8'h10 + j), 8'(8'h20 + j)});
        repeat (24) @(posedge clk);
        lit[0] = 8'h03; lit[1] = 8'h00;
        for (int j = 0; j < 7; j++) begin
            lit[2 + 2*j] = 8'(8'h20 + j);
            lit[3 + 2*j] = 8'(8'h10 + j);
        end
        check(cap_n == 16, "R6 cluster size", cap_n, 16);
        for (int i = 0; i < 16; i++)
            check(cap_d[i] === lit[i], "R6 R9 byte layout", cap_d[i], lit[i]);
    endtask

    task automatic t_partial();
        do_reset();
        for (int i = 0; i < 6; i++) push_tick(1'b1, 2'd1, 16'(16'h3C5A + i));
        repeat (30) @(posedge clk);
        check(cap_n == 0, "R7 six events silent", cap_n, 0);
        push_tick(1'b1, 2'd1, 16'h0F0F);
        compare("R7 seventh releases");
    endtask

    task automatic t_gap();
        do_reset();
        for (int i = 0; i < 2; i++) push_tick(1'b1, 2'd0, 16'(16'hBEE0 + i));
        for (int i = 0; i < 10; i++) push_tick(1'b0, 2'd0, 16'hDEAD);
        for (int i = 0; i < 5; i++) push_tick(1'b1, 2'd0, 16'(16'h1230 + i));
        for (int i = 0; i < 20; i++) push_tick(1'b0, 2'd2, 16'h5555);
        for (int i = 0; i < 7; i++) push_tick(1'b1, 2'd2, 16'(16'h7001 * (i + 1)));
        compare("R9 gap clusters");
        check(cap_n > 17 && cap_d[16] == 8'd37 && cap_d[17] == 8'd0,
              "R8 second header", {cap_d[17], cap_d[16]}, 37);
    endtask

    task automatic t_latency();
        do_reset();
        for (int i = 0; i < 6; i++) push_tick(1'b1, 2'd0, 16'(i));
        model_tick(1'b1, 2'd0, 16'h0077);
        @(posedge clk); #1;
        tick = 1'b1; keep = 1'b1; samples = 16'h0077;
        @(posedge clk); #1;
        tick = 1'b0; keep = 1'b0;
        @(negedge clk);
        check(!out_valid, "R11 no byte at edge E", out_valid, 0);
        @(negedge clk);
        check(out_valid && out_addr == 10'd0 && out_data == 8'd0, "R11 first byte at E+1",
              {out_valid, out_addr}, {1'b1, 10'd0});
        for (int i = 1; i < 16; i++) begin
            @(negedge clk);
            check(out_valid && out_addr == 10'(i), "R11 consecutive bytes", out_addr, i);
        end
        @(negedge clk);
        check(!out_valid, "R11 burst ends", out_valid, 0);
        compare("R11 content");
    endtask

    task automatic t_wrap();
        do_reset();
        @(posedge clk); #1;
        tick = 1'b1; keep = 1'b0;
        repeat (65534) @(posedge clk);
        #1 tick = 1'b0;
        m_ts += 65534;
        for (int i = 0; i < 14; i++) push_tick(1'b1, 2'd3, 16'(16'h8421 + 16'h0111 * i));
        compare("R8 R5 timestamp wrap");
        check(cap_d[0] == 8'hFE && cap_d[1] == 8'hFF, "R8 header FFFE",
              {cap_d[1], cap_d[0]}, 16'hFFFE);
        check(cap_n > 17 && cap_d[16] == 8'h05 && cap_d[17] == 8'h00, "R8 header after wrap",
              {cap_d[17], cap_d[16]}, 5);
    endtask

    task automatic t_chunk();
        int dones;
        int done_at;
        do_reset();
        for (int i = 0; i < 65*7; i++)
            push_tick(1'b1, 2'(i % 3), 16'(16'h9E37 * (i + 3)));
        compare("R10 chunk data");
        dones = 0; done_at = -1;
        for (int i = 0; i < cap_n; i++)
            if (cap_c[i]) begin dones++; done_at = i; end
        check(dones == 1, "R10 one strobe", dones, 1);
        check(done_at == 1023, "R10 strobe position", done_at, 1023);
        check(cap_n == 1040 && cap_a[1024] == 10'd0, "R10 address wrap", cap_a[1024], 0);
    endtask

    initial begin
        t_reset();
        t_mode(2'd0, "R2 16x1");
        t_mode(2'd1, "R3 8x2");
        t_mode(2'd2, "R4 4x4");
        t_mode(2'd3, "R5 alt mode");
        t_layout();
        t_partial();
        t_gap();
        t_latency();
        t_chunk();
        t_wrap();
        report();
        $finish;
    end
endmodule